// File: doc/BRIEF.md
# Indirect Word-Memory Access Bridge

This block lets a host that only has an 8-bit register bus reach a large external memory organised as 16-bit words. The host never addresses the memory directly. It loads a 25-bit word address that is spread over five byte registers, places write data in (or collects read data from) two data byte registers, and then sets a start bit. The start bit launches one memory access and stays set for as long as the access is in flight. The host learns that the access has finished by reading the start bit back as 0.

The command register packs three things: the lowest five word-address bits, a two-bit byte-lane enable and the start bit. Both lane enables low means a read. Lane enable 1 writes the upper data byte, lane enable 0 writes the lower data byte, and both together write the whole word. On the memory side the block raises a request and holds it, together with a frozen address, lane mask and write data, until the memory answers with a one-cycle acknowledge. On a read, that acknowledge also carries the returned word.

The register window sits at a parameterised base offset (default 30h). Offsets base+0 to base+4 hold the address and command. Offsets base+5 and base+6 hold the low and high data bytes.

Top module: `xmem_bridge`

## Requirements
- R1: After reset every register in the window reads 0 and `mem_req` is low.
- R2: The word address on `mem_addr` is assembled as follows. Bits [4:0] come from command register bits 4:0. Bits [7:5] come from base+0 bits 7:5. Bits [15:8] come from base+1. Bits [23:16] come from base+2. Bit [24] comes from base+3 bit 0.
- R3: Base+0 bits 4:0 and base+3 bits 7:1 are reserved. They always read 0 and writes to them are dropped.
- R4: A register read returns the current contents combinationally, in the same cycle that `reg_addr` is presented.
- R5: A host write to base+4 with bit 7 set, made while idle, raises `mem_req` at the next clock edge. `mem_req` then stays high until `mem_ack`.
- R6: Lane enables 00 (base+4 bits 6:5) make a read: `mem_we` is low. The word on `mem_rdata` at the acknowledge is loaded into the data registers, low byte at base+5 and high byte at base+6.
- R7: Non-zero lane enables make a write. `mem_we` is high, `mem_be` equals the enables (bit 1 is the upper byte, bit 0 the lower byte) and `mem_wdata` is {base+6, base+5}.
- R8: The start bit (base+4 bit 7) reads 1 while an access is in flight. It reads 0 from the clock edge that samples `mem_acknowledge` onward, and `mem_req` falls at that same edge.
- R9: While an access is in flight, host writes to any address, command or data register are ignored. This includes a second start. The memory-side outputs stay frozen.
- R10: Offsets base+7 and any address outside the window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | REG_AW | Host register offset |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 2 | Byte lane mask, bit 1 = upper byte |
| mem_addr | output | 25 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | 16 | Read data, valid with acknowledge |

## Verification
The bench walks a single one across all 25 address bits, so a scrambled bit in the scattered address map shows up as a wrong `mem_addr` or a wrong returned word. It runs all four lane-enable codes over a set of words and reads every word back. A design that swapped the byte lanes, or wrote both lanes on a single-lane write, therefore leaves the wrong bytes in memory. With a long memory latency it hammers the address, command and data registers and issues a second start. A design that does not lock these during an access would move `mem_addr`, issue an extra write or clobber the returned data. It also writes all ones into the reserved bits and reads the unused offsets, which catches reserved bits that store data.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   localparam int WORD_AW  = 25;
   localparam int LANES    = 2;
   localparam int DATA_W   = 8 * LANES;
   localparam int SLOT_W   = 3;

   typedef enum logic [SLOT_W-1:0] {
      SLOT_ADDR_A = 3'd0,
      SLOT_ADDR_B = 3'd1,
      SLOT_ADDR_C = 3'd2,
      SLOT_ADDR_D = 3'd3,
      SLOT_CMD    = 3'd4,
      SLOT_DLO    = 3'd5,
      SLOT_DHI    = 3'd6,
      SLOT_NONE   = 3'd7
   } slot_e;

   typedef struct packed {
      logic [LANES-1:0]  lane_en;
      logic [WORD_AW-1:0] waddr;
   } cmd_t;
endpackage

// File: rtl/xmem_addr_regs.sv
module xmem_addr_regs
   import xmem_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  slot_e       slot,
   input  logic [7:0]  wdata,
   output cmd_t        cmd
);
   cmd_t cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_en) begin
         unique case (slot)
            SLOT_ADDR_A: cmd_q.waddr[7:5]   <= wdata[7:5];
            SLOT_ADDR_B: cmd_q.waddr[15:8]  <= wdata;
            SLOT_ADDR_C: cmd_q.waddr[23:16] <= wdata;
            SLOT_ADDR_D: cmd_q.waddr[24]    <= wdata[0];
            SLOT_CMD: begin
               cmd_q.waddr[4:0] <= wdata[4:0];
               cmd_q.lane_en    <= wdata[6:5];
            end
            default: ;
         endcase
      end
   end

   assign cmd = cmd_q;
endmodule

// File: rtl/xmem_data_lanes.sv
module xmem_data_lanes
   import xmem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  slot_e             slot,
   input  logic [7:0]        wdata,
   input  logic              load_rd,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] data
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam slot_e MY_SLOT = slot_e'(int'(SLOT_DLO) + l);
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (load_rd)
            byte_q <= rd_word[8*l +: 8];
         else if (wr_en && slot == MY_SLOT)
            byte_q <= wdata;
      end
      assign data[8*l +: 8] = byte_q;
   end
endmodule

// File: rtl/xmem_ctl.sv
module xmem_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic ack,
   output logic busy
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (busy_q && ack)
         busy_q <= 1'b0;
      else if (launch)
         busy_q <= 1'b1;
   end

   assign busy = busy_q;
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
   import xmem_pkg::*;
#(
   parameter int              REG_AW = 8,
   parameter logic [REG_AW-1:0] BASE = 8'h30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [1:0]         mem_be,
   output logic [24:0]        mem_addr,
   output logic [15:0]        mem_wdata,
   input  logic               mem_ack,
   input  logic [15:0]        mem_rdata
);
   localparam int HI_W = REG_AW - SLOT_W;

   if (REG_AW < 4) begin : g_bad_aw
      $error("xmem_bridge: REG_AW must be at least 4");
   end
   if (BASE[SLOT_W-1:0] != '0) begin : g_bad_base
      $error("xmem_bridge: BASE must be aligned to 8");
   end

   logic        hit;
   slot_e       slot;
   logic        busy;
   logic        host_wr;
   logic        launch;
   logic        load_rd;
   cmd_t        cmd;
   logic [15:0] data;

   assign hit     = (reg_addr[REG_AW-1:SLOT_W] == BASE[REG_AW-1:SLOT_W]);
   assign slot    = slot_e'(reg_addr[SLOT_W-1:0]);
   assign host_wr = reg_wr && hit && !busy;
   assign launch  = host_wr && (slot == SLOT_CMD) && reg_wdata[7];
   assign load_rd = busy && mem_ack && (cmd.lane_en == 2'b00);

   xmem_addr_regs u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (host_wr),
      .slot  (slot),
      .wdata (reg_wdata),
      .cmd   (cmd)
   );

   xmem_data_lanes u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_wr),
      .slot    (slot),
      .wdata   (reg_wdata),
      .load_rd (load_rd),
      .rd_word (mem_rdata),
      .data    (data)
   );

   xmem_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .ack    (mem_ack),
      .busy   (busy)
   );

   always_comb begin
      reg_rdata = 8'h00;
      if (hit) begin
         unique case (slot)
            SLOT_ADDR_A: reg_rdata = {cmd.waddr[7:5], 5'b0};
            SLOT_ADDR_B: reg_rdata = cmd.waddr[15:8];
            SLOT_ADDR_C: reg_rdata = cmd.waddr[23:16];
            SLOT_ADDR_D: reg_rdata = {7'b0, cmd.waddr[24]};
            SLOT_CMD:    reg_rdata = {busy, cmd.lane_en, cmd.waddr[4:0]};
            SLOT_DLO:    reg_rdata = data[7:0];
            SLOT_DHI:    reg_rdata = data[15:8];
            default:     reg_rdata = 8'h00;
         endcase
      end
   end

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = '0;

   assign mem_req   = busy;
   assign mem_we    = |cmd.lane_en;
   assign mem_be    = cmd.lane_en;
   assign mem_addr  = cmd.waddr;
   assign mem_wdata = data;
endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk #(
   parameter int                REG_AW = 8,
   parameter logic [REG_AW-1:0] BASE   = 8'h30
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] reg_addr,
   input logic              reg_wr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        reg_rdata,
   input logic              mem_req,
   input logic              mem_we,
   input logic [1:0]        mem_be,
   input logic [24:0]       mem_addr,
   input logic [15:0]       mem_wdata,
   input logic              mem_ack
);
   localparam logic [REG_AW-1:0] CMD_OFS = BASE + REG_AW'(4);
   localparam logic [REG_AW-1:0] TOP_OFS = BASE + REG_AW'(3);

   p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req && reg_wr && reg_addr == CMD_OFS && reg_wdata[7]) |=> mem_req);

   p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);

   p_ack_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> !mem_req);

   p_busy_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CMD_OFS) |-> (reg_rdata[7] == mem_req));

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_be) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

   p_rsvd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == BASE) |-> (reg_rdata[4:0] == 5'b0));

   p_rsvd_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == TOP_OFS) |-> (reg_rdata[7:1] == 7'b0));
endmodule

bind xmem_bridge xmem_bridge_chk #(.REG_AW(REG_AW), .BASE(BASE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_be    (mem_be),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/xmem_bridge_bench.sv
`timescale 1ns/1ps
module xmem_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        mem_req, mem_we;
   logic [1:0]  mem_be;
   logic [24:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = 16'h0;

   int tests = 0;
   int fails = 0;
   int lat = 0;
   int cnt = 0;
   int nwrites = 0;
   logic [15:0] mem [0:63];
   logic [15:0] ref_mem [0:63];

   always #4 clk = ~clk;

   xmem_bridge u_xmem_bridge (.*);

   // behavioural memory: acknowledge after lat extra cycles
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (cnt >= lat) begin
            cnt     <= 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               nwrites <= nwrites + 1;
               if (mem_be[1]) mem[mem_addr[5:0]][15:8] <= mem_wdata[15:8];
               if (mem_be[0]) mem[mem_addr[5:0]][7:0]  <= mem_wdata[7:0];
            end else begin
               mem_rdata <= mem[mem_addr[5:0]];
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_addr(logic [24:0] wa);
      wr(8'h30, {wa[7:5], 5'b0});
      wr(8'h31, wa[15:8]);
      wr(8'h32, wa[23:16]);
      wr(8'h33, {7'b0, wa[24]});
   endtask

   task automatic launch(logic [24:0] wa, logic [1:0] en);
      wr(8'h34, {1'b1, en, wa[4:0]});
      chk("R5 request raised", {31'b0, mem_req}, 32'd1);
      chk("R2 word address", {7'b0, mem_addr}, {7'b0, wa});
   endtask

   task automatic wait_done();
      logic [7:0] v;
      for (int i = 0; i < 300; i++) begin
         rd(8'h34, v);
         if (!v[7]) break;
         @(negedge clk);
      end
      rd(8'h34, v);
      chk("R8 start bit cleared", {31'b0, v[7]}, 32'd0);
      chk("R8 request dropped", {31'b0, mem_req}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      logic [7:0]  v;
      logic [24:0] wa;
      logic [15:0] d;
      for (int i = 0; i < 64; i++) begin
         mem[i]     = 16'(i * 16'h1357 + 16'h0A0B);
         ref_mem[i] = 16'(i * 16'h1357 + 16'h0A0B);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 8'h30; a <= 8'h36; a++) begin
         rd(8'(a), v);
         chk("R1 reset register value", {24'b0, v}, 32'd0);
      end
      chk("R1 reset request", {31'b0, mem_req}, 32'd0);

      // R3 / R4 / R10
      wr(8'h30, 8'hFF); rd(8'h30, v);
      chk("R3 reserved bits at base+0", {24'b0, v}, 32'hE0);
      wr(8'h33, 8'hFF); rd(8'h33, v);
      chk("R3 reserved bits at base+3", {24'b0, v}, 32'h01);
      wr(8'h31, 8'h5A); rd(8'h31, v);
      chk("R4 same-cycle readback", {24'b0, v}, 32'h5A);
      wr(8'h37, 8'hFF); rd(8'h37, v);
      chk("R10 unused slot reads 0", {24'b0, v}, 32'h0);
      rd(8'h2F, v);
      chk("R10 outside window reads 0", {24'b0, v}, 32'h0);
      rd(8'h3F, v);
      chk("R10 outside window reads 0", {24'b0, v}, 32'h0);

      // R2 / R6: walking one over the word address, reads
      for (int b = 0; b < 25; b++) begin
         lat = b % 3;
         wa  = 25'(1) << b;
         set_addr(wa);
         launch(wa, 2'b00);
         chk("R6 read flag", {31'b0, mem_we}, 32'd0);
         wait_done();
         rd(8'h35, v);
         chk("R6 low data byte", {24'b0, v}, {24'b0, ref_mem[wa[5:0]][7:0]});
         rd(8'h36, v);
         chk("R6 high data byte", {24'b0, v}, {24'b0, ref_mem[wa[5:0]][15:8]});
      end

      // R7: every lane-enable code across several words
      for (int en = 0; en < 4; en++) begin
         for (int k = 0; k < 8; k++) begin
            lat = (en + k) % 4;
            wa  = {19'(k * 4099 + en), 6'(k)};
            d   = 16'(16'hC3A5 ^ (en * 16'h1111) ^ (k * 16'h0F17));
            wr(8'h35, d[7:0]);
            wr(8'h36, d[15:8]);
            set_addr(wa);
            launch(wa, 2'(en));
            if (en != 0) begin
               chk("R7 write flag", {31'b0, mem_we}, 32'd1);
               chk("R7 lane mask", {30'b0, mem_be}, 32'(en));
               chk("R7 write data", {16'b0, mem_wdata}, {16'b0, d});
            end
            wait_done();
            if (en[1]) ref_mem[k][15:8] = d[15:8];
            if (en[0]) ref_mem[k][7:0]  = d[7:0];
            rd(8'h35, v);
            chk("R6/R7 low data register after access", {24'b0, v},
                {24'b0, (en == 0) ? ref_mem[k][7:0] : d[7:0]});
            rd(8'h36, v);
            chk("R6/R7 high data register after access", {24'b0, v},
                {24'b0, (en == 0) ? ref_mem[k][15:8] : d[15:8]});
         end
      end
      for (int k = 0; k < 8; k++) begin
         lat = 1;
         set_addr(25'(k));
         launch(25'(k), 2'b00);
         wait_done();
         rd(8'h35, v);
         chk("R7 masked write result low", {24'b0, v}, {24'b0, ref_mem[k][7:0]});
         rd(8'h36, v);
         chk("R7 masked write result high", {24'b0, v}, {24'b0, ref_mem[k][15:8]});
      end

      // R9: writes while busy are ignored
      lat = 20;
      wa  = 25'h0A5_3C12;
      set_addr(wa);
      begin
         int w0;
         w0 = nwrites;
         launch(wa, 2'b00);
         wr(8'h31, 8'hFF);
         wr(8'h34, 8'hFF);
         wr(8'h35, 8'hAA);
         wr(8'h36, 8'h55);
         wr(8'h30, 8'h00);
         wr(8'h33, 8'h00);
         chk("R9 address frozen while busy", {7'b0, mem_addr}, {7'b0, wa});
         chk("R9 still a read while busy", {31'b0, mem_we}, 32'd0);
         wait_done();
         repeat (30) @(negedge clk);
         chk("R9 second start ignored", 32'(nwrites), 32'(w0));
         chk("R9 no new request", {31'b0, mem_req}, 32'd0);
      end
      rd(8'h30, v); chk("R9 base+0 unchanged", {24'b0, v}, {24'b0, wa[7:5], 5'b0});
      rd(8'h31, v); chk("R9 base+1 unchanged", {24'b0, v}, {24'b0, wa[15:8]});
      rd(8'h33, v); chk("R9 base+3 unchanged", {24'b0, v}, {31'b0, wa[24]});
      rd(8'h34, v); chk("R9 command unchanged", {24'b0, v}, {24'b0, 3'b000, wa[4:0]});
      rd(8'h35, v); chk("R9 read data kept", {24'b0, v}, {24'b0, ref_mem[wa[5:0]][7:0]});
      rd(8'h36, v); chk("R9 read data kept", {24'b0, v}, {24'b0, ref_mem[wa[5:0]][15:8]});

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule